// File: doc/BRIEF.md
# Set/Clear GPIO Port Register Bank

This block is a 32-pin general-purpose I/O port controlled through a simple memory-mapped register bus. It has a write strobe, a read strobe, a byte address, write data and read data. For each pin it holds an output value, a direction bit, a pull-disable bit and two alternate-function select bits. The output value and the direction can each be changed through their own write-one-to-set and write-one-to-clear addresses. Software can therefore flip single pins without a read-modify-write. The same two registers can also be loaded whole through their plain addresses.

The pad side sees three buses: output-enable, output-value and pull-disable. It also sees the two alternate-function buses; per pin, the pair {B, A} forms the mode, and 00 means plain GPIO. Incoming pin levels pass through a two-flop synchronizer before software reads them. Reset clears every register, so every pin starts as a GPIO input with its pull enabled.

Top module: `gpio_port_regs`

## Requirements
- R1: After a synchronous active-low reset, pad_oe, pad_out, pad_pull_dis, alt_sel_a and alt_sel_b are all zero, and so are the readable registers at 0x0C, 0x10, 0x20 and 0x24.
- R2: A write to 0x04 (output-set) makes every pad_out bit that is 1 in the write data high, from the clock edge that takes the write.
- R3: A write to 0x08 (output-clear) makes every pad_out bit that is 1 in the write data low, from the clock edge that takes the write.
- R4: Bits that are 0 in a write to any set or clear address (0x04, 0x08, 0x14, 0x18) leave their register bits unchanged.
- R5: A write to 0x14 (direction-set) turns pins into outputs (pad_oe bit 1). A write to 0x18 (direction-clear) turns them into inputs. Reading 0x10 returns the direction, with 1 meaning output.
- R6: A write to 0x00 replaces the whole output-value register. A write to 0x10 replaces the whole direction register.
- R7: Reading 0x00 returns the pin levels on pad_in as seen through two flops. A level applied before clock edge N is still hidden after edge N and is returned after edge N+1.
- R8: 0x0C is a read/write pull-disable register driving pad_pull_dis. A 0 bit means the pull is enabled.
- R9: 0x20 (select A) and 0x24 (select B) are read/write registers driving alt_sel_a and alt_sel_b. The mode of pin i is {alt_sel_b[i], alt_sel_a[i]}, and 00 is plain GPIO.
- R10: The set and clear addresses read as 0, and so does any unmapped address. A write to an unmapped address changes no register. When bus_rd is low, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_rd | input | 1 | Read strobe, read data valid in the same cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 32 | Asynchronous pin levels from the pads |
| pad_oe | output | 32 | Per-pin output enable (direction register) |
| pad_out | output | 32 | Per-pin output value |
| pad_pull_dis | output | 32 | Per-pin pull disable, 0 = pull enabled |
| alt_sel_a | output | 32 | Alternate-function select A per pin |
| alt_sel_b | output | 32 | Alternate-function select B per pin |

## Verification
The hardest condition to reach from the ports is the exact latency of the input synchronizer. A register read shows a flop's output, so the boundary between "still old" and "now new" must be sampled cycle by cycle. The bench changes pad_in just after one edge, reads 0x00 after the next edge and expects the old level, then reads again one edge later and expects the new one. The atomic writes are hard in a different way: a plain overwrite would also pass a test that writes all ones. The bench therefore loads mixed patterns first and then uses set and clear masks that overlap bits already at the target value, as well as bits that are not.

// File: rtl/gpio_port_pkg.sv
// Package: register offsets and shared constants for the GPIO port bank.
// Assumes byte addresses and word-aligned registers.
package gpio_port_pkg;
    localparam int unsigned OFF_DATA     = 'h00;
    localparam int unsigned OFF_DATA_SET = 'h04;
    localparam int unsigned OFF_DATA_CLR = 'h08;
    localparam int unsigned OFF_PULL_DIS = 'h0C;
    localparam int unsigned OFF_DIR      = 'h10;
    localparam int unsigned OFF_DIR_SET  = 'h14;
    localparam int unsigned OFF_DIR_CLR  = 'h18;
    localparam int unsigned OFF_ALT_A    = 'h20;
    localparam int unsigned OFF_ALT_B    = 'h24;

    // Number of plain read/write registers (pull-disable, select A, select B).
    localparam int unsigned NUM_PLAIN = 3;

    // Pin mode encoding formed as {select B, select A}.
    typedef enum logic [1:0] {
        MODE_GPIO = 2'b00,
        MODE_ALT1 = 2'b01,
        MODE_ALT2 = 2'b10,
        MODE_ALT3 = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer for the asynchronous pad inputs.
// Assumes each bit is independent (no multi-bit coherence is needed).
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [1:0]   warm_cnt;

    // Capture and retime the pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    // Count clean cycles since reset so the latency check starts only once it is valid.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_cnt <= '0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end

    assign sync_out = stage2;

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt >= 2'd2) |-> (sync_out == $past(async_in, 2))); // R7
endmodule

// File: rtl/gpio_setclr_reg.sv
// Module: register with whole-word load plus write-one-to-set and
// write-one-to-clear updates. Assumes at most one strobe per cycle
// (the address decoder guarantees this).
module gpio_setclr_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_full,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Apply a load, a set mask or a clear mask to the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (wr_full) q <= wdata;
        else if (wr_set)  q <= q | wdata;
        else if (wr_clr)  q <= q & ~wdata;
    end

    AST_SET_FORCES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((q & $past(wdata)) == $past(wdata))); // R2
    AST_CLR_FORCES_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((q & $past(wdata)) == '0)); // R3
    AST_MASK_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set || wr_clr) |=> (((q ^ $past(q)) & ~$past(wdata)) == '0)); // R4
endmodule

// File: rtl/gpio_plain_reg.sv
// Module: plain read/write register with a single write enable.
// Assumes the write enable is already qualified by the address decode.
module gpio_plain_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Load the word on a write, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/gpio_port_regs.sv
// Module: top of the GPIO port register bank. Decodes the bus, holds the
// output value, direction, pull-disable and alternate-select registers,
// and returns the synchronized pin levels on reads of the data address.
// Assumes single-cycle bus accesses with combinational read data.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_pull_dis,
    output logic [NPINS-1:0]  alt_sel_a,
    output logic [NPINS-1:0]  alt_sel_b
);
    localparam logic [ADDR_W-1:0] A_DATA     = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_DATA_SET = ADDR_W'(OFF_DATA_SET);
    localparam logic [ADDR_W-1:0] A_DATA_CLR = ADDR_W'(OFF_DATA_CLR);
    localparam logic [ADDR_W-1:0] A_PULL_DIS = ADDR_W'(OFF_PULL_DIS);
    localparam logic [ADDR_W-1:0] A_DIR      = ADDR_W'(OFF_DIR);
    localparam logic [ADDR_W-1:0] A_DIR_SET  = ADDR_W'(OFF_DIR_SET);
    localparam logic [ADDR_W-1:0] A_DIR_CLR  = ADDR_W'(OFF_DIR_CLR);
    localparam logic [ADDR_W-1:0] A_ALT_A    = ADDR_W'(OFF_ALT_A);
    localparam logic [ADDR_W-1:0] A_ALT_B    = ADDR_W'(OFF_ALT_B);
    localparam logic [ADDR_W-1:0] PLAIN_ADDR [NUM_PLAIN] = '{A_PULL_DIS, A_ALT_A, A_ALT_B};

    logic [NPINS-1:0] pin_level;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] plain_q [NUM_PLAIN];

    // Synchronize the pad levels before anything reads them.
    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_level)
    );

    // Output-value register with its atomic set and clear addresses.
    gpio_setclr_reg #(.W(NPINS)) u_out_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_full (bus_wr && (bus_addr == A_DATA)),
        .wr_set  (bus_wr && (bus_addr == A_DATA_SET)),
        .wr_clr  (bus_wr && (bus_addr == A_DATA_CLR)),
        .wdata   (bus_wdata),
        .q       (out_q)
    );

    // Direction register with its atomic set and clear addresses.
    gpio_setclr_reg #(.W(NPINS)) u_dir_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_full (bus_wr && (bus_addr == A_DIR)),
        .wr_set  (bus_wr && (bus_addr == A_DIR_SET)),
        .wr_clr  (bus_wr && (bus_addr == A_DIR_CLR)),
        .wdata   (bus_wdata),
        .q       (dir_q)
    );

    // Plain read/write registers: pull-disable, select A, select B.
    for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
        gpio_plain_reg #(.W(NPINS)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_wr && (bus_addr == PLAIN_ADDR[g])),
            .wdata (bus_wdata),
            .q     (plain_q[g])
        );
    end

    // Read multiplexer; set/clear and unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_DATA:     bus_rdata = pin_level;
                A_DIR:      bus_rdata = dir_q;
                A_PULL_DIS: bus_rdata = plain_q[0];
                A_ALT_A:    bus_rdata = plain_q[1];
                A_ALT_B:    bus_rdata = plain_q[2];
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign pad_out      = out_q;
    assign pad_oe       = dir_q;
    assign pad_pull_dis = plain_q[0];
    assign alt_sel_a    = plain_q[1];
    assign alt_sel_b    = plain_q[2];

    logic addr_mapped;
    assign addr_mapped = (bus_addr == A_DATA) || (bus_addr == A_DATA_SET) ||
                         (bus_addr == A_DATA_CLR) || (bus_addr == A_PULL_DIS) ||
                         (bus_addr == A_DIR) || (bus_addr == A_DIR_SET) ||
                         (bus_addr == A_DIR_CLR) || (bus_addr == A_ALT_A) ||
                         (bus_addr == A_ALT_B);

    AST_RESET_ALL_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && pad_pull_dis == '0 &&
                          alt_sel_a == '0 && alt_sel_b == '0)); // R1
    AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !addr_mapped) |=> ($stable(pad_out) && $stable(pad_oe) &&
            $stable(pad_pull_dis) && $stable(alt_sel_a) && $stable(alt_sel_b))); // R10
endmodule

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;
    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_out;
        logic [31:0] exp_oe;
    } vec_t;

    // Write vectors walked in order; each expectation follows from the requirements.
    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{8'h04, 32'hF0F0_0001, 32'hF0F0_0001, 32'h0000_0000}, // R2 set
        '{8'h08, 32'h0000_0F01, 32'hF0F0_0000, 32'h0000_0000}, // R3 clear
        '{8'h14, 32'h0000_FFFF, 32'hF0F0_0000, 32'h0000_FFFF}, // R5 dir set
        '{8'h18, 32'h0000_00F0, 32'hF0F0_0000, 32'h0000_FF0F}, // R5 dir clear
        '{8'h04, 32'h0000_0000, 32'hF0F0_0000, 32'h0000_FF0F}, // R4 zero mask
        '{8'h00, 32'h1234_5678, 32'h1234_5678, 32'h0000_FF0F}, // R6 full data
        '{8'h10, 32'hA5A5_0000, 32'h1234_5678, 32'hA5A5_0000}, // R6 full dir
        '{8'h08, 32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_0000}, // R3 clear all
        '{8'h14, 32'h8000_0001, 32'h0000_0000, 32'hA5A5_0001}, // R4 overlap set
        '{8'h3C, 32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_0001}  // R10 unmapped
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe, pad_out, pad_pull_dis, alt_sel_a, alt_sel_b;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pull_dis(pad_pull_dis), .alt_sel_a(alt_sel_a), .alt_sel_b(alt_sel_b)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);

        // Table walk: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VEC[i].addr, VEC[i].wdata);
            check($sformatf("R2/R3/R4/R5/R6/R10 vec %0d pad_out", i), pad_out, VEC[i].exp_out);
            check($sformatf("R2/R3/R4/R5/R6/R10 vec %0d pad_oe", i), pad_oe, VEC[i].exp_oe);
        end

        // R5: direction readback
        bus_read(8'h10, rd); check("R5 dir read", rd, 32'hA5A5_0001);
        // R10: set/clear and unmapped reads are zero, no read strobe gives zero
        bus_read(8'h04, rd); check("R10 read 0x04", rd, 32'h0);
        bus_read(8'h08, rd); check("R10 read 0x08", rd, 32'h0);
        bus_read(8'h14, rd); check("R10 read 0x14", rd, 32'h0);
        bus_read(8'h18, rd); check("R10 read 0x18", rd, 32'h0);
        bus_read(8'h3C, rd); check("R10 read unmapped", rd, 32'h0);
        bus_addr = 8'h10; #1; check("R10 no strobe", bus_rdata, 32'h0);

        // R8: pull-disable
        bus_write(8'h0C, 32'h0000_FFFF);
        check("R8 pad_pull_dis", pad_pull_dis, 32'h0000_FFFF);
        bus_read(8'h0C, rd); check("R8 read", rd, 32'h0000_FFFF);

        // R9: alternate selects; pin1 mode {B,A} = 11, pin0 = 01, pin2 = 10
        bus_write(8'h20, 32'h0000_0003);
        bus_write(8'h24, 32'h0000_0006);
        check("R9 alt_sel_a", alt_sel_a, 32'h3);
        check("R9 alt_sel_b", alt_sel_b, 32'h6);
        check("R9 pin1 mode", {30'h0, alt_sel_b[1], alt_sel_a[1]}, 32'h3);
        bus_read(8'h20, rd); check("R9 read A", rd, 32'h3);
        bus_read(8'h24, rd); check("R9 read B", rd, 32'h6);

        // R7: synchronizer latency
        @(negedge clk); pad_in = 32'hDEAD_BEEF;
        @(negedge clk); bus_read(8'h00, rd); check("R7 after one edge", rd, 32'h0);
        @(negedge clk); bus_read(8'h00, rd); check("R7 after two edges", rd, 32'hDEAD_BEEF);
        @(negedge clk); pad_in = 32'h0000_0001;
        @(negedge clk); bus_read(8'h00, rd); check("R7 hold old", rd, 32'hDEAD_BEEF);
        @(negedge clk); bus_read(8'h00, rd); check("R7 new level", rd, 32'h0000_0001);

        // R1: reset after programming
        bus_write(8'h04, 32'hFFFF_FFFF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 pad_out after reset", pad_out, 32'h0);
        check("R1 pad_oe after reset", pad_oe, 32'h0);
        check("R1 pad_pull_dis after reset", pad_pull_dis, 32'h0);
        check("R1 alt_sel_a after reset", alt_sel_a, 32'h0);
        check("R1 alt_sel_b after reset", alt_sel_b, 32'h0);
        bus_read(8'h10, rd); check("R1 read dir", rd, 32'h0);
        bus_read(8'h0C, rd); check("R1 read pull", rd, 32'h0);
        bus_read(8'h20, rd); check("R1 read alt A", rd, 32'h0);
        bus_read(8'h24, rd); check("R1 read alt B", rd, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule